// File: doc/BRIEF.md
# Serial Memory Slave with Hold and Write Protect

This block is the serial front end of a byte-addressed nonvolatile memory. A host drives a mode-0 serial bus (chip select, clock, data in) plus two active-low side pins: a suspend pin and a status-guard pin. The block decodes an 8-bit command, collects a two-byte address, and then streams bytes into or out of an internal 8 KB array. The address steps by one after every byte and wraps at the top of the array. A small status register holds a write-enable latch and a two-bit region-protection code.

All pins are brought into a system clock domain through a synchronizer. Serial clock edges are then detected as single-cycle events. The suspend pin freezes a transfer partway through: clock and select activity are ignored, and the output is released until the pin is de-asserted. The status-guard pin blocks only writes to the status register. Array writes are governed by the protection code. The tri-stated output is modelled as a data bit plus an output-enable.

Top module: `spi_mem_slave`

## Requirements
- R1: While chip select is high, the output enable is low and serial clock and data activity change no state. In particular, clocking the set-enable command with select high leaves the status byte at its prior value.
- R2: A frame starts only on a falling edge of chip select. The bit position and command decoding restart there, so a frame abandoned after a partial byte does not affect the next frame.
- R3: Input bits are taken on rising serial clock edges and output bits change only after falling edges. All bytes are sent most significant bit first.
- R4: Command 06h sets the write-enable latch and 04h clears it. Command 05h streams the status byte repeatedly, laid out as {4'b0000, prot[1:0] at bits 3:2, latch at bit 1, 1'b0}. The status byte reads 00h after reset.
- R5: Command 03h takes a 16-bit address, most significant byte first, and ignores its top 3 bits. It then returns bytes from consecutive addresses.
- R6: While streaming, the address advances by one per byte and wraps from 1FFFh to 0000h.
- R7: Command 02h writes consecutive bytes only when the latch is set. The latch clears when select rises at the end of any 02h or 01h frame.
- R8: Command 01h loads bits 3:2 of its first data byte into the protection code. This happens only if the latch is set and the guard pin is high; with the guard pin low the code is unchanged.
- R9: Protection code 00 locks nothing, 01 locks 1800h-1FFFh, 10 locks 1000h-1FFFh, and 11 locks the whole array. A byte aimed at a locked address is dropped, but the address still advances.
- R10: While the suspend pin is low, clock edges and select transitions are ignored. When the pin returns high, a read or write continues from the exact bit where it stopped.
- R11: The output enable is high only during the data phase of a 03h or 05h frame, and is forced low whenever the transfer is suspended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Active-low suspend, changed only while sck is low |
| wp_n | input | 1 | Active-low guard for status register writes |
| so | output | 1 | Serial data to host |
| so_oe | output | 1 | Output enable for so (high means driven) |

## Verification
The bench aims at the edges of the address space and the protection regions. A stream that crosses 1FFFh must land at 0000h; a design that saturates or stops would return stale data there. Writes that run from an unlocked address into a locked one, and from a locked one back to 0000h, expose a design that stalls its address on a dropped byte: the byte after the locked span would be written to the wrong place. Suspending a transfer mid-byte, while toggling the clock and pulsing select, catches a design that counts those edges: the read stream would come back shifted, or the write would store garbage. The status-guard and latch-clearing cases show whether the guard pin leaks into array writes or the latch survives a write frame.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

   localparam logic [7:0] CMD_SET_WE = 8'h06;
   localparam logic [7:0] CMD_CLR_WE = 8'h04;
   localparam logic [7:0] CMD_GET_ST = 8'h05;
   localparam logic [7:0] CMD_PUT_ST = 8'h01;
   localparam logic [7:0] CMD_READ   = 8'h03;
   localparam logic [7:0] CMD_WRITE  = 8'h02;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR,
      PH_RDATA,
      PH_WDATA,
      PH_SOUT,
      PH_SIN,
      PH_SINK
   } phase_t;

   // region lock decode from protection code and the two top address bits
   function automatic logic region_locked(input logic [1:0] prot, input logic [1:0] top2);
      case (prot)
         2'b00:   region_locked = 1'b0;
         2'b01:   region_locked = (top2 == 2'b11);
         2'b10:   region_locked = top2[1];
         default: region_locked = 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) pipe[k] <= RST_VAL;
            end else begin
               pipe[0] <= d;
               for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
   parameter int ADDR_W     = 13,
   parameter int LANE_BYTES = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);

   localparam int LW    = $clog2(LANE_BYTES);
   localparam int WORDS = (2 ** ADDR_W) / LANE_BYTES;

   generate
      if (LANE_BYTES < 1 || (2 ** LW) != LANE_BYTES) begin : g_bad_lanes
         $error("LANE_BYTES must be a power of two");
      end

      if (LANE_BYTES == 1) begin : g_bytes
         logic [7:0] mem [WORDS];
         always_ff @(posedge clk) begin
            if (we) mem[addr] <= wdata;
         end
         assign rdata = mem[addr];
      end else begin : g_words
         logic [LANE_BYTES*8-1:0] mem [WORDS];
         logic [LANE_BYTES*8-1:0] word;
         always_ff @(posedge clk) begin
            if (we) mem[addr[ADDR_W-1:LW]][{addr[LW-1:0], 3'b000} +: 8] <= wdata;
         end
         assign word  = mem[addr[ADDR_W-1:LW]];
         assign rdata = word[{addr[LW-1:0], 3'b000} +: 8];
      end
   endgenerate

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
   import spi_mem_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int ADDR_BYTES  = 2,
   parameter int SYNC_STAGES = 2,
   parameter int LANE_BYTES  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   input  logic hold_n,
   input  logic wp_n,
   output logic so,
   output logic so_oe
);

   localparam int ACC_W = (ADDR_BYTES - 1) * 8;
   localparam int AB_W  = (ADDR_BYTES > 2) ? $clog2(ADDR_BYTES) : 1;

   generate
      if (ADDR_BYTES < 2 || ADDR_W > ADDR_BYTES * 8 || ADDR_W < 3) begin : g_bad_addr
         $error("address width does not fit the address bytes");
      end
   endgenerate

   // synchronized pins
   logic s_cs_n, s_sck, s_si, s_hold_n, s_wp_n;
   spi_mem_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b10011)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({cs_n, sck, si, hold_n, wp_n}),
      .q    ({s_cs_n, s_sck, s_si, s_hold_n, s_wp_n})
   );

   logic sck_d, susp, cs_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         susp  <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_d <= s_sck;
         if (!s_sck) susp <= ~s_hold_n;  // suspend level follows the pin only while sck is low
         if (!susp)  cs_q <= s_cs_n;     // select edges are not seen while suspended
      end
   end

   logic frame_start, frame_end, rise_ev, fall_ev;
   assign frame_start = cs_q & ~s_cs_n & ~susp;
   assign frame_end   = ~cs_q & s_cs_n & ~susp;
   assign rise_ev     = s_sck & ~sck_d & ~susp & ~cs_q;
   assign fall_ev     = ~s_sck & sck_d & ~susp & ~cs_q;

   phase_t            phase;
   logic [2:0]        bit_cnt;
   logic [6:0]        sh;
   logic [ACC_W-1:0]  acc;
   logic [AB_W-1:0]   abyte;
   logic              rd_cmd, wel, wr_frame, reload, so_q;
   logic [1:0]        prot;
   logic [7:0]        tx, byte_in, status_byte, mem_rdata;
   logic [ADDR_W-1:0] addr;
   logic              byte_done, wr_byte, locked, mem_we, sreg_we, out_phase;

   assign byte_in     = {sh, s_si};
   assign byte_done   = rise_ev && (bit_cnt == 3'd7);
   assign status_byte = {4'b0000, prot, wel, 1'b0};
   assign locked      = region_locked(prot, addr[ADDR_W-1 -: 2]);
   assign wr_byte     = byte_done && (phase == PH_WDATA);
   assign mem_we      = wr_byte && wel && !locked;
   assign sreg_we     = byte_done && (phase == PH_SIN) && wel && s_wp_n;
   assign out_phase   = (phase == PH_RDATA) || (phase == PH_SOUT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_SINK;
         bit_cnt  <= '0;
         sh       <= '0;
         acc      <= '0;
         abyte    <= '0;
         rd_cmd   <= 1'b0;
         wel      <= 1'b0;
         wr_frame <= 1'b0;
         reload   <= 1'b0;
         so_q     <= 1'b0;
         prot     <= 2'b00;
         tx       <= '0;
         addr     <= '0;
      end else begin
         reload <= 1'b0;
         if (reload) begin
            tx   <= mem_rdata;
            addr <= addr + 1'b1;
         end
         if (frame_start) begin
            phase    <= PH_CMD;
            bit_cnt  <= '0;
            abyte    <= '0;
            wr_frame <= 1'b0;
         end else if (frame_end) begin
            if (wr_frame) wel <= 1'b0;
            wr_frame <= 1'b0;
            phase    <= PH_SINK;
         end else begin
            if (rise_ev) begin
               sh      <= byte_in[6:0];
               bit_cnt <= bit_cnt + 1'b1;
            end
            if (fall_ev && out_phase) begin
               so_q <= tx[7];
               tx   <= {tx[6:0], 1'b0};
            end
            if (byte_done) begin
               case (phase)
                  PH_CMD: begin
                     case (byte_in)
                        CMD_SET_WE: begin wel <= 1'b1; phase <= PH_SINK; end
                        CMD_CLR_WE: begin wel <= 1'b0; phase <= PH_SINK; end
                        CMD_GET_ST: begin tx <= status_byte; phase <= PH_SOUT; end
                        CMD_PUT_ST: begin wr_frame <= 1'b1; phase <= PH_SIN; end
                        CMD_READ:   begin rd_cmd <= 1'b1; phase <= PH_ADDR; end
                        CMD_WRITE:  begin rd_cmd <= 1'b0; wr_frame <= 1'b1; phase <= PH_ADDR; end
                        default:    phase <= PH_SINK;
                     endcase
                  end
                  PH_ADDR: begin
                     acc <= ACC_W'({acc, byte_in});
                     if (abyte == AB_W'(ADDR_BYTES - 1)) begin
                        addr   <= ADDR_W'({acc, byte_in});
                        phase  <= rd_cmd ? PH_RDATA : PH_WDATA;
                        reload <= rd_cmd;
                     end else begin
                        abyte <= abyte + 1'b1;
                     end
                  end
                  PH_RDATA: reload <= 1'b1;
                  PH_WDATA: addr <= addr + 1'b1;
                  PH_SOUT:  tx <= status_byte;
                  PH_SIN: begin
                     if (sreg_we) prot <= byte_in[3:2];
                     phase <= PH_SINK;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   spi_mem_array #(.ADDR_W(ADDR_W), .LANE_BYTES(LANE_BYTES)) u_array (
      .clk  (clk),
      .we   (mem_we),
      .addr (addr),
      .wdata(byte_in),
      .rdata(mem_rdata)
   );

   assign so    = so_q;
   assign so_oe = ~cs_q & ~susp & out_phase;

endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk #(
   parameter int ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_q,
   input logic              s_cs_n,
   input logic              s_wp_n,
   input logic              susp,
   input logic              fall_ev,
   input logic              so,
   input logic              mem_we,
   input logic              wr_byte,
   input logic [1:0]        prot,
   input logic [ADDR_W-1:0] addr
);

   p_idle_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_q && s_cs_n) |=> $stable(addr));

   p_so_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_ev |=> $stable(so));

   p_write_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (addr == ADDR_W'($past(addr) + 1'b1)));

   p_guard_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !s_wp_n |=> $stable(prot));

   p_drop_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_byte |=> (addr == ADDR_W'($past(addr) + 1'b1)));

   p_suspend_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      susp |=> $stable(addr));

endmodule

bind spi_mem_slave spi_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cs_q   (cs_q),
   .s_cs_n (s_cs_n),
   .s_wp_n (s_wp_n),
   .susp   (susp),
   .fall_ev(fall_ev),
   .so     (so),
   .mem_we (mem_we),
   .wr_byte(wr_byte),
   .prot   (prot),
   .addr   (addr)
);

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
   logic so, so_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_mem_slave u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe)
   );

   typedef struct {
      logic [7:0] val;
      string      tag;
   } exp_t;

   exp_t       exp_q[$];
   int         n_cmp = 0;
   int         n_bad = 0;
   bit         done = 1'b0;
   logic [7:0] mon_sh = '0;
   int         mon_n = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, expv);
      end
   endtask

   // monitor: assembles output bytes and scores them against the queue
   always @(negedge cs_n) if (hold_n) mon_n = 0;

   always @(posedge sck) begin
      if (!cs_n && so_oe === 1'b1) begin
         mon_sh = {mon_sh[6:0], so};
         mon_n++;
         if (mon_n == 8) begin
            exp_t e;
            mon_n = 0;
            if (exp_q.size() == 0) begin
               n_cmp++;
               n_bad++;
               $display("FAIL R11 unexpected output byte: got %0h expected none", mon_sh);
            end else begin
               e = exp_q.pop_front();
               check(e.tag, {24'd0, mon_sh}, {24'd0, e.val});
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clk_bit(input logic b);
      @(negedge clk) si = b;
      tick(HALF);
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) clk_bit(b[i]);
   endtask

   task automatic open_f();
      tick(2);
      cs_n = 1'b0;
      tick(HALF);
   endtask

   task automatic close_f();
      tick(HALF);
      cs_n = 1'b1;
      tick(2 * HALF);
   endtask

   task automatic op_only(input logic [7:0] op);
      open_f(); send(op); close_f();
   endtask

   task automatic expect_in(input logic [7:0] v, input string tag);
      exp_q.push_back('{val: v, tag: tag});
      send(8'h00);
   endtask

   task automatic rd_status(input logic [7:0] v, input string tag);
      open_f();
      send(8'h05);
      expect_in(v, tag);
      expect_in(v, tag);
      close_f();
   endtask

   task automatic wr_status(input logic [7:0] v);
      op_only(8'h06);
      open_f(); send(8'h01); send(v); close_f();
   endtask

   task automatic wr_mem(input logic [15:0] a, input logic [31:0] d, input int n);
      open_f();
      send(8'h02); send(a[15:8]); send(a[7:0]);
      for (int i = 0; i < n; i++) send(d[31-8*i -: 8]);
      close_f();
   endtask

   task automatic rd_mem(input logic [15:0] a, input logic [31:0] d, input int n, input string tag);
      open_f();
      send(8'h03); send(a[15:8]); send(a[7:0]);
      for (int i = 0; i < n; i++) expect_in(d[31-8*i -: 8], tag);
      close_f();
   endtask

   // suspend mid-transfer, disturb clock and select, then resume
   task automatic hold_seq(input string tag);
      tick(HALF);
      hold_n = 1'b0;
      tick(6);
      check({tag, " R11 output off while suspended"}, {31'd0, so_oe}, 32'd0);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk) si = 1'b1;
         tick(HALF); sck = 1'b1; tick(HALF); sck = 1'b0;
         check({tag, " R11 output stays off"}, {31'd0, so_oe}, 32'd0);
      end
      tick(2); cs_n = 1'b1; tick(HALF); cs_n = 1'b0; tick(HALF);
      hold_n = 1'b1;
      tick(6);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      check("R1 output disabled after reset", {31'd0, so_oe}, 32'd0);
      rd_status(8'h00, "R4 status after reset");

      // R1: clock a set-enable command with select high
      for (int i = 7; i >= 0; i--) begin
         clk_bit(CMD_BIT(i));
         check("R1 output disabled while idle", {31'd0, so_oe}, 32'd0);
      end
      rd_status(8'h00, "R1 idle clocking ignored");

      op_only(8'h06); rd_status(8'h02, "R4 set enable");
      op_only(8'h04); rd_status(8'h00, "R4 clear enable");

      op_only(8'h06); wr_mem(16'h0010, 32'hAABB0000, 2);
      rd_status(8'h00, "R7 latch cleared by write frame");
      wr_mem(16'h0010, 32'h11220000, 2);
      rd_mem(16'h0010, 32'hAABB0000, 2, "R7 R3 write without latch dropped");
      rd_mem(16'hE010, 32'hAA000000, 1, "R5 upper address bits ignored");

      op_only(8'h06); wr_mem(16'h1FFF, 32'hC1C20000, 2);
      rd_mem(16'h1FFF, 32'hC1C20000, 2, "R6 wrap at top of array");

      op_only(8'h06); wr_mem(16'h17FE, 32'h01020304, 4);
      op_only(8'h06); wr_mem(16'h0FFF, 32'hF0F10000, 2);
      rd_mem(16'h17FE, 32'h01020304, 4, "R5 streaming read");

      // R2: abandoned partial frame
      open_f(); clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b0); close_f();
      rd_status(8'h00, "R2 fresh frame after partial byte");

      wr_status(8'h04); rd_status(8'h04, "R8 protection code loaded");
      op_only(8'h06); wr_mem(16'h17FE, 32'h11121314, 4);
      rd_mem(16'h17FE, 32'h11120304, 4, "R9 upper quarter locked");
      op_only(8'h06); wr_mem(16'h1FFE, 32'hD1D2D300, 3);
      rd_mem(16'h1FFF, 32'hC1D30000, 2, "R9 dropped bytes still advance");

      wr_status(8'h08);
      op_only(8'h06); wr_mem(16'h0FFF, 32'hE1E20000, 2);
      rd_mem(16'h0FFF, 32'hE1F10000, 2, "R9 upper half locked");

      wr_status(8'h0C);
      op_only(8'h06); wr_mem(16'h0010, 32'h77000000, 1);
      rd_mem(16'h0010, 32'hAA000000, 1, "R9 whole array locked");
      rd_status(8'h0C, "R7 latch cleared by status write frame");

      wp_n = 1'b0;
      wr_status(8'h00); rd_status(8'h0C, "R8 guard pin blocks status write");
      wp_n = 1'b1;
      wr_status(8'h00); rd_status(8'h00, "R8 status write with guard high");

      // R10: suspend during a write stream
      op_only(8'h06);
      open_f();
      send(8'h02); send(8'h00); send(8'h20); send(8'h5C);
      hold_seq("R10 write");
      send(8'h5D);
      close_f();
      rd_mem(16'h0020, 32'h5C5D0000, 2, "R10 suspended write resumes");

      // R10: suspend in the middle of an output byte
      open_f();
      send(8'h03); send(8'h00); send(8'h20);
      exp_q.push_back('{val: 8'h5C, tag: "R10 suspended read resumes"});
      clk_bit(1'b0); clk_bit(1'b0); clk_bit(1'b0);
      hold_seq("R10 read");
      for (int i = 0; i < 5; i++) clk_bit(1'b0);
      expect_in(8'h5D, "R10 read continues after resume");
      close_f();
      check("R11 output off after frame", {31'd0, so_oe}, 32'd0);

      check("R11 every expected byte was driven", exp_q.size(), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      done = 1'b1;
      $finish;
   end

   function automatic logic CMD_BIT(input int i);
      logic [7:0] c;
      c = 8'h06;
      return c[i];
   endfunction

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule